// File: doc/BRIEF.md
# Two-Level Nested Interrupt Arbiter

This block chooses which of five interrupt sources a small CPU services next. The sources are external line 0, timer 0, external line 1, timer 1 and the serial port. Software programs two 8-bit registers. The enable register holds a master switch and one enable per source. The priority register marks each source as high or low level.

The CPU marks one clock of each machine cycle with `mc_strobe`. On that clock the block latches the raw request lines. On the strobe of the next machine cycle it polls the latched copy against the enables, the priorities and the levels now in service. If a source wins, the block raises `call_req` for one clock and drives `call_vec` with the 16-bit entry address of that source. At the same time it marks the winner's level as in service.

The two levels nest. A low-level service can be interrupted by a high-level request. A high-level service cannot be interrupted. The CPU pulses `reti_pulse` when a handler ends, which releases the innermost active level. It holds `hold_off` high while it must not be interrupted.

Top module: `nested_irq_ctrl`

## Requirements
- R1: After reset both configuration registers read 0x00, `call_req` is 0, `call_vec` is 0x0000 and both in-service flags are 0.
- R2: A write with `cfg_sel`=0 loads the enable register. Bit 7 is the master enable and bits 4..0 enable the sources: bit 0 external 0, bit 1 timer 0, bit 2 external 1, bit 3 timer 1, bit 4 serial. Bits 6..5 are ignored and read 0, so writing 0xFF reads back 0x9F.
- R3: While the master enable bit is 0, no source is acknowledged, whatever the per-source enables say.
- R4: A write with `cfg_sel`=1 loads the priority register, using the same bit positions as R2. A 1 marks a source as high level. Bits 7..5 are ignored and read 0, so writing 0xFF reads back 0x1F.
- R5: When requests of both levels are eligible on the same poll, a high-level source wins.
- R6: Within one level the lowest bit index wins. The order is external 0, timer 0, external 1, timer 1, serial.
- R7: Request lines are latched only on `mc_strobe` clocks and polled on the next strobe. A request present at strobe N gives `call_req` in the clock after strobe N+1. A request that comes and goes between two strobes is never acknowledged.
- R8: The vector is 0x0003 + 8 × (bit index): 0x0003, 0x000B, 0x0013, 0x001B and 0x0023.
- R9: While a low-level service is active, only high-level sources are acknowledged. While a high-level service is active, nothing is acknowledged.
- R10: A `reti_pulse` clears the high in-service flag if it is set, and otherwise clears the low one. With neither flag set, it changes nothing.
- R11: If `hold_off` is 1 on a polling strobe, no acknowledge occurs on that strobe.
- R12: An acknowledge raises `call_req` for exactly one clock and sets the in-service flag of the winner's level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mc_strobe | input | 1 | One clock per machine cycle: latch requests and poll the previous latch |
| req_in | input | 5 | Raw request flags, bit index as in R2 |
| hold_off | input | 1 | CPU-side condition that blocks acknowledge on this strobe |
| reti_pulse | input | 1 | Return-from-interrupt, releases the innermost level |
| cfg_we | input | 1 | Configuration write enable |
| cfg_sel | input | 1 | 0 selects the enable register, 1 selects the priority register |
| cfg_wdata | input | 8 | Configuration write data |
| en_rd | output | 8 | Enable register contents |
| pri_rd | output | 8 | Priority register contents |
| call_req | output | 1 | One-clock request to enter a handler |
| call_vec | output | 16 | Handler entry address, valid with call_req |
| busy_hi | output | 1 | High-level service in progress |
| busy_lo | output | 1 | Low-level service in progress |

## Verification
The hardest state to reach is a low-level service that has been pre-empted by a high-level one. Both in-service flags are set at once, so two returns must then peel them off in the right order. Ports alone reach it only through a fixed chain of steps. First a timer 1 acknowledge at low level. Then a blocked low-level request, to show the low service is active. Then an external 0 request marked high, which must interrupt. Then a second high request that must not interrupt. The bench walks this chain strobe by strobe and reads both in-service flags after each return. A separate sequence keeps a request asserted across a held strobe, which shows that `hold_off` only defers the acknowledge and does not lose the request.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  // Entry address of the handler for source idx.
  function automatic logic [31:0] vec_addr(logic [31:0] base,
                                           logic [31:0] stride,
                                           logic [31:0] idx);
    return base + stride * idx;
  endfunction

  // Mask that keeps the low nsrc bits and, if gie >= 0, bit gie as well.
  function automatic logic [31:0] keep_mask(int nsrc, int gie);
    logic [31:0] m;
    m = '0;
    for (int i = 0; i < nsrc; i++) m[i] = 1'b1;
    if (gie >= 0) m[gie] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/irqc_cfg_regs.sv
module irqc_cfg_regs #(
  parameter int NSRC    = 5,
  parameter int REG_W   = 8,
  parameter int GIE_BIT = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic             sel,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] en_q,
  output logic [REG_W-1:0] pri_q
);
  localparam logic [REG_W-1:0] EN_KEEP  = REG_W'(irqc_pkg::keep_mask(NSRC, GIE_BIT));
  localparam logic [REG_W-1:0] PRI_KEEP = REG_W'(irqc_pkg::keep_mask(NSRC, -1));

  logic wr_en_reg;
  logic wr_pri_reg;
  assign wr_en_reg  = we && !sel;
  assign wr_pri_reg = we && sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      pri_q <= '0;
    end else begin
      if (wr_en_reg)  en_q  <= wdata & EN_KEEP;
      if (wr_pri_reg) pri_q <= wdata & PRI_KEEP;
    end
  end

  AST_EN_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q & ~EN_KEEP) == '0); // R2
  AST_PRI_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (pri_q & ~PRI_KEEP) == '0); // R4
  AST_EN_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_reg |=> $stable(en_q)); // R2
endmodule

// File: rtl/irqc_sampler.sv
module irqc_sampler #(
  parameter int NSRC = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            strobe,
  input  logic [NSRC-1:0] req_raw,
  output logic [NSRC-1:0] smp_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      smp_q <= '0;
    else if (strobe) smp_q <= req_raw;
  end

  AST_SAMPLE_ONLY_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> $stable(smp_q)); // R7
endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter #(
  parameter int NSRC  = 5,
  parameter int IDX_W = $clog2(NSRC)
) (
  input  logic [NSRC-1:0]  cand_hi,
  input  logic [NSRC-1:0]  cand_lo,
  input  logic             active_hi,
  input  logic             active_lo,
  output logic             grant,
  output logic             grant_hi,
  output logic [IDX_W-1:0] grant_idx
);
  logic             hi_open;
  logic             lo_open;
  logic             hi_any;
  logic             lo_any;
  logic [IDX_W-1:0] first_hi;
  logic [IDX_W-1:0] first_lo;

  assign hi_open = !active_hi;
  assign lo_open = !active_hi && !active_lo;
  assign hi_any  = |cand_hi;
  assign lo_any  = |cand_lo;

  // Fixed poll order: lowest index first, found by scanning downward.
  always_comb begin
    first_hi = '0;
    first_lo = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (cand_hi[i]) first_hi = IDX_W'(i);
      if (cand_lo[i]) first_lo = IDX_W'(i);
    end
  end

  always_comb begin
    grant     = 1'b0;
    grant_hi  = 1'b0;
    grant_idx = '0;
    if (hi_open && hi_any) begin
      grant     = 1'b1;
      grant_hi  = 1'b1;
      grant_idx = first_hi;
    end else if (lo_open && lo_any) begin
      grant     = 1'b1;
      grant_idx = first_lo;
    end
  end
endmodule

// File: rtl/irqc_level_track.sv
module irqc_level_track (
  input  logic clk,
  input  logic rst_n,
  input  logic ack,
  input  logic ack_hi,
  input  logic reti,
  output logic busy_hi_q,
  output logic busy_lo_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_hi_q <= 1'b0;
      busy_lo_q <= 1'b0;
    end else begin
      if (reti) begin
        if (busy_hi_q)      busy_hi_q <= 1'b0;
        else if (busy_lo_q) busy_lo_q <= 1'b0;
      end
      if (ack) begin
        if (ack_hi) busy_hi_q <= 1'b1;
        else        busy_lo_q <= 1'b1;
      end
    end
  end

  AST_ACK_SETS_HI: assert property (@(posedge clk) disable iff (!rst_n)
    ack && ack_hi |=> busy_hi_q); // R12
  AST_ACK_SETS_LO: assert property (@(posedge clk) disable iff (!rst_n)
    ack && !ack_hi |=> busy_lo_q); // R12
  AST_RETI_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    reti && !ack && !busy_hi_q && !busy_lo_q |=> !busy_hi_q && !busy_lo_q); // R10
  AST_RETI_HI_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    reti && !ack && busy_hi_q |=> !busy_hi_q && (busy_lo_q == $past(busy_lo_q))); // R10
  AST_ONLY_RETI_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !reti && busy_lo_q |=> busy_lo_q); // R10
endmodule

// File: rtl/nested_irq_ctrl.sv
module nested_irq_ctrl #(
  parameter int NSRC       = 5,
  parameter int REG_W      = 8,
  parameter int GIE_BIT    = 7,
  parameter int VEC_W      = 16,
  parameter int VEC_BASE   = 3,
  parameter int VEC_STRIDE = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mc_strobe,
  input  logic [NSRC-1:0]  req_in,
  input  logic             hold_off,
  input  logic             reti_pulse,
  input  logic             cfg_we,
  input  logic             cfg_sel,
  input  logic [REG_W-1:0] cfg_wdata,
  output logic [REG_W-1:0] en_rd,
  output logic [REG_W-1:0] pri_rd,
  output logic             call_req,
  output logic [VEC_W-1:0] call_vec,
  output logic             busy_hi,
  output logic             busy_lo
);
  localparam int IDX_W = $clog2(NSRC);

  logic [REG_W-1:0] en_q;
  logic [REG_W-1:0] pri_q;
  logic [NSRC-1:0]  smp_q;
  logic [NSRC-1:0]  live;
  logic [NSRC-1:0]  cand_hi;
  logic [NSRC-1:0]  cand_lo;
  logic             grant;
  logic             grant_hi;
  logic [IDX_W-1:0] grant_idx;
  logic             ack_fire;
  logic [VEC_W-1:0] vec_next;
  logic             call_hi_q;

  irqc_cfg_regs #(.NSRC(NSRC), .REG_W(REG_W), .GIE_BIT(GIE_BIT)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .en_q(en_q), .pri_q(pri_q)
  );

  irqc_sampler #(.NSRC(NSRC)) u_smp (
    .clk(clk), .rst_n(rst_n), .strobe(mc_strobe), .req_raw(req_in), .smp_q(smp_q)
  );

  assign live    = smp_q & en_q[NSRC-1:0] & {NSRC{en_q[GIE_BIT]}};
  assign cand_hi = live & pri_q[NSRC-1:0];
  assign cand_lo = live & ~pri_q[NSRC-1:0];

  irqc_arbiter #(.NSRC(NSRC), .IDX_W(IDX_W)) u_arb (
    .cand_hi(cand_hi), .cand_lo(cand_lo),
    .active_hi(busy_hi), .active_lo(busy_lo),
    .grant(grant), .grant_hi(grant_hi), .grant_idx(grant_idx)
  );

  assign ack_fire = mc_strobe && !hold_off && grant;
  assign vec_next = VEC_W'(irqc_pkg::vec_addr(32'(VEC_BASE), 32'(VEC_STRIDE), 32'(grant_idx)));

  irqc_level_track u_lvl (
    .clk(clk), .rst_n(rst_n), .ack(ack_fire), .ack_hi(grant_hi), .reti(reti_pulse),
    .busy_hi_q(busy_hi), .busy_lo_q(busy_lo)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      call_req  <= 1'b0;
      call_vec  <= '0;
      call_hi_q <= 1'b0;
    end else begin
      call_req  <= ack_fire;
      call_vec  <= ack_fire ? vec_next : '0;
      call_hi_q <= ack_fire && grant_hi;
    end
  end

  assign en_rd  = en_q;
  assign pri_rd = pri_q;

  AST_GLOBAL_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    call_req |-> $past(en_q[GIE_BIT])); // R3
  AST_CALL_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    call_req |-> $past(mc_strobe)); // R7
  AST_HOLD_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    call_req |-> !$past(hold_off)); // R11
  AST_HI_NO_PREEMPT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy_hi) |-> !call_req); // R9
  AST_LO_NEST_HI_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    call_req && $past(busy_lo) |-> call_hi_q); // R9
  AST_VEC_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    call_req |-> call_vec[2:0] == 3'd3); // R8
endmodule

// File: tb/nested_irq_ctrl_test.sv
`timescale 1ns/1ps
module nested_irq_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mc_strobe = 1'b0;
  logic [4:0]  req_in = '0;
  logic        hold_off = 1'b0;
  logic        reti_pulse = 1'b0;
  logic        cfg_we = 1'b0;
  logic        cfg_sel = 1'b0;
  logic [7:0]  cfg_wdata = '0;
  logic [7:0]  en_rd;
  logic [7:0]  pri_rd;
  logic        call_req;
  logic [15:0] call_vec;
  logic        busy_hi;
  logic        busy_lo;

  int  n_run = 0;
  int  n_fail = 0;
  bit  done = 1'b0;

  always #2.5 clk = ~clk;

  nested_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .mc_strobe(mc_strobe), .req_in(req_in),
    .hold_off(hold_off), .reti_pulse(reti_pulse), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .en_rd(en_rd), .pri_rd(pri_rd),
    .call_req(call_req), .call_vec(call_vec), .busy_hi(busy_hi), .busy_lo(busy_lo)
  );

  // {enable, priority, request, expect call, expected vector}
  localparam logic [47:0] TBL [9] = '{
    {8'h9F, 8'h00, 8'h1F, 8'h01, 16'h0003},
    {8'h9F, 8'h00, 8'h1E, 8'h01, 16'h000B},
    {8'h9F, 8'h00, 8'h18, 8'h01, 16'h001B},
    {8'h9F, 8'h00, 8'h10, 8'h01, 16'h0023},
    {8'h9F, 8'h10, 8'h1F, 8'h01, 16'h0023},
    {8'h9F, 8'h0C, 8'h0D, 8'h01, 16'h0013},
    {8'h1F, 8'h00, 8'h1F, 8'h00, 16'h0000},
    {8'h82, 8'h00, 8'h1F, 8'h01, 16'h000B},
    {8'h80, 8'h00, 8'h1F, 8'h00, 16'h0000}
  };

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic cfg_write(logic sel, logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic reti();
    @(negedge clk);
    reti_pulse = 1'b1;
    @(negedge clk);
    reti_pulse = 1'b0;
  endtask

  // One machine cycle: strobe for one clock, observe the registered call right after.
  task automatic mcycle(output logic c, output logic [15:0] v);
    @(negedge clk);
    mc_strobe = 1'b1;
    @(negedge clk);
    mc_strobe = 1'b0;
    c = call_req;
    v = call_vec;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic        c;
    logic [15:0] v;

    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 call_req", call_req, 0);
    check("R1 call_vec", call_vec, 0);
    check("R1 en_rd", en_rd, 0);
    check("R1 pri_rd", pri_rd, 0);
    check("R1 busy", {busy_hi, busy_lo}, 0);

    // Table walk: R3 R5 R6 R8 R2
    foreach (TBL[k]) begin
      do_reset();
      cfg_write(1'b0, TBL[k][47:40]);
      cfg_write(1'b1, TBL[k][39:32]);
      req_in = TBL[k][28:24];
      mcycle(c, v);
      req_in = '0;
      mcycle(c, v);
      check($sformatf("R5 R6 R8 R3 entry %0d call", k), c, TBL[k][16]);
      check($sformatf("R8 entry %0d vec", k), v, TBL[k][15:0]);
    end

    // R2 R4 reserved bits
    do_reset();
    cfg_write(1'b0, 8'hFF);
    check("R2 enable readback", en_rd, 8'h9F);
    cfg_write(1'b1, 8'hFF);
    check("R4 priority readback", pri_rd, 8'h1F);

    // R7 latency and missed pulse, R12 single-clock call
    do_reset();
    cfg_write(1'b0, 8'h9F);
    @(negedge clk); req_in = 5'h04;
    @(negedge clk); req_in = 5'h00;
    mcycle(c, v);
    mcycle(c, v);
    check("R7 pulse between strobes ignored", c, 0);
    req_in = 5'h04;
    mcycle(c, v);
    check("R7 no call on latching strobe", c, 0);
    req_in = 5'h00;
    @(negedge clk); mc_strobe = 1'b1;
    @(negedge clk); mc_strobe = 1'b0;
    check("R7 call on next strobe", call_req, 1);
    check("R8 external 1 vector", call_vec, 16'h0013);
    @(negedge clk);
    check("R12 call lasts one clock", call_req, 0);
    check("R12 low level busy", {busy_hi, busy_lo}, 2'b01);

    // R9 R10 nesting
    do_reset();
    cfg_write(1'b0, 8'h9F);
    cfg_write(1'b1, 8'h01);
    req_in = 5'h08; mcycle(c, v); req_in = '0; mcycle(c, v);
    check("R12 timer 1 low ack", v, 16'h001B);
    check("R12 busy after low ack", {busy_hi, busy_lo}, 2'b01);
    req_in = 5'h02; mcycle(c, v); req_in = '0; mcycle(c, v);
    check("R9 low blocked by low", c, 0);
    req_in = 5'h01; mcycle(c, v); req_in = '0; mcycle(c, v);
    check("R9 high preempts low", c, 1);
    check("R9 high vector", v, 16'h0003);
    check("R9 both busy", {busy_hi, busy_lo}, 2'b11);
    req_in = 5'h01; mcycle(c, v); req_in = '0; mcycle(c, v);
    check("R9 high not preempted", c, 0);
    reti();
    check("R10 first return clears high", {busy_hi, busy_lo}, 2'b01);
    reti();
    check("R10 second return clears low", {busy_hi, busy_lo}, 2'b00);
    reti();
    check("R10 idle return no effect", {busy_hi, busy_lo}, 2'b00);
    check("R10 idle return keeps config", {en_rd, pri_rd}, 16'h9F01);

    // R11 hold_off defers
    do_reset();
    cfg_write(1'b0, 8'h9F);
    req_in = 5'h02;
    mcycle(c, v);
    hold_off = 1'b1;
    mcycle(c, v);
    check("R11 held strobe no call", c, 0);
    hold_off = 1'b0;
    mcycle(c, v);
    check("R11 call after release", c, 1);
    check("R11 vector after release", v, 16'h000B);
    req_in = '0;

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule